// File: doc/BRIEF.md
# Timeslot Subchannel Bit Masking Processor

This block sits between a byte-wide FIFO and one 8-bit timeslot that comes round once per 125 µs frame, a full rate of 8 kbyte/s. A mask byte picks which bit positions of the slot carry channel data. Any 8-bit pattern is allowed. On the transmit side the block builds each outgoing slot byte. Unmasked positions take channel data and masked positions take a programmable fill byte. On the receive side it takes the data bits out of each incoming slot byte and hands bytes to the receive FIFO.

There are two modes. In transparent mode the FIFO moves exactly one byte per frame whatever the mask, so the FIFO rate stays at 8 kbyte/s. In packed mode only the unmasked bits move. Bits carry over from frame to frame until whole bytes are formed, so the FIFO rate shrinks in proportion to the mask's population count. A narrow control channel uses packed mode with a two-bit mask, which gives one FIFO byte every four frames.

A two-state controller sequences the work. It has two states and these transitions:
- `ST_IDLE` is the wait state. On `frame_stb` it latches the configuration and the received slot, then moves to `ST_WORK`.
- `ST_WORK` is the one processing cycle. It returns to `ST_IDLE`, or stays in `ST_WORK` when another strobe arrives.

Top module: `slot_bitmask_engine`

## Requirements
- R1: A synchronous reset `rst` clears every output to zero and empties both the transmit bit reservoir and the receive accumulator, so the first packed frame after reset pops a fresh byte.
- R2: Mask, fill and mode are sampled only in the cycle `frame_stb` is high, and `rx_slot` is captured in that same cycle. Changes at any other time have no effect on that frame.
- R3: Transparent transmit: slot bit i equals FIFO data bit i where mask bit i is 1 and fill bit i where it is 0. Exactly one byte is popped per frame for any mask, including all-zero.
- R4: Transparent receive: each frame pushes one byte equal to the captured slot AND the mask, so masked positions read 0.
- R5: Packed transmit: unmasked slot positions, taken in ascending index order, receive reservoir bits least significant first. A FIFO byte is popped, and appended above the bits already held, only when the reservoir holds fewer bits than the mask's population count.
- R6: Packed receive: unmasked slot bits, in ascending index order, are appended to an accumulator. A byte is pushed whenever 8 bits are present, and the first gathered bit lands at bit 0.
- R7: In packed mode an all-zero mask pops nothing, pushes nothing and sends the fill byte unchanged.
- R8: When transmit needs a byte and `txf_empty` is high, there is no pop. Every unmasked slot bit is driven to 1, `tx_underrun` pulses for one cycle, and in packed mode the reservoir keeps its contents.
- R9: When a byte is due for the receive FIFO and `rxf_full` is high, the byte is dropped, `rx_overrun` pulses for one cycle, and no push occurs.
- R10: With `frame_stb` high at clock edge n, `txf_pop` is asserted between edges n and n+1. After edge n+1, `tx_slot_vld`, `tx_slot`, `tx_underrun`, `rxf_push`, `rxf_data` and `rx_overrun` show that frame's results for one cycle.
- R11: A frame processed in transparent mode empties the reservoir and the accumulator.
- R12: A two-bit mask in packed mode pops one byte and pushes one byte every four frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | Frame start pulse, samples configuration and slot |
| cfg_packed | input | 1 | Mode: 0 transparent, 1 packed |
| cfg_mask | input | 8 | Mask byte, 1 = data position |
| cfg_fill | input | 8 | Fill value for masked transmit positions |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_data | input | 8 | Transmit FIFO head byte (show-ahead) |
| txf_pop | output | 1 | Transmit FIFO pop |
| tx_slot | output | 8 | Outgoing slot byte |
| tx_slot_vld | output | 1 | `tx_slot` updated this cycle |
| tx_underrun | output | 1 | Transmit underrun pulse |
| rx_slot | input | 8 | Incoming slot byte, captured at `frame_stb` |
| rxf_full | input | 1 | Receive FIFO full |
| rxf_push | output | 1 | Receive FIFO push |
| rxf_data | output | 8 | Byte for the receive FIFO |
| rx_overrun | output | 1 | Receive overrun pulse |

## Verification
Each frame's pop decision is due in the single cycle after the strobe edge. The bench samples it at the falling edge of that cycle, while `txf_data`, `txf_empty` and `rxf_full` are still held. The slot byte, the push, the received byte and both error pulses are due one edge later, and they are read at the next falling edge. One further cycle is then read to confirm the strobes have dropped. Configuration and `rx_slot` are scrambled immediately after the strobe edge, so any late sampling changes the expected slot or received byte.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    typedef enum logic {
        MODE_TRANSP = 1'b0,
        MODE_PACKED = 1'b1
    } sbm_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WORK = 1'b1
    } sbm_state_e;

endpackage

// File: rtl/sbm_frame_ctrl.sv
module sbm_frame_ctrl
    import sbm_pkg::*;
#(
    parameter int SLOT_W = 8,
    localparam int CNT_W = $clog2(2 * SLOT_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  sbm_mode_e         cfg_mode,
    input  logic [SLOT_W-1:0] cfg_mask,
    input  logic [SLOT_W-1:0] cfg_fill,
    input  logic [SLOT_W-1:0] rx_slot,
    output logic              work,
    output sbm_mode_e         act_mode,
    output logic [SLOT_W-1:0] act_mask,
    output logic [SLOT_W-1:0] act_fill,
    output logic [CNT_W-1:0]  act_need,
    output logic [SLOT_W-1:0] rx_lat
);

    sbm_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: state_nxt = frame_stb ? ST_WORK : ST_IDLE;
            ST_WORK: state_nxt = frame_stb ? ST_WORK : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        work = (state == ST_WORK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_mode <= MODE_TRANSP;
            act_mask <= '0;
            act_fill <= '0;
            act_need <= '0;
            rx_lat   <= '0;
        end else if (frame_stb) begin
            act_mode <= cfg_mode;
            act_mask <= cfg_mask;
            act_fill <= cfg_fill;
            act_need <= CNT_W'($countones(cfg_mask));
            rx_lat   <= rx_slot;
        end
    end

    AST_WORK_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        work |-> $past(frame_stb));                                   // R10
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> ($stable(act_mask) && $stable(act_fill)));    // R2

endmodule

// File: rtl/sbm_tx_path.sv
module sbm_tx_path
    import sbm_pkg::*;
#(
    parameter int SLOT_W = 8,
    localparam int RES_W = 2 * SLOT_W,
    localparam int CNT_W = $clog2(RES_W + 1),
    localparam int IDX_W = $clog2(RES_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              work,
    input  sbm_mode_e         act_mode,
    input  logic [SLOT_W-1:0] act_mask,
    input  logic [SLOT_W-1:0] act_fill,
    input  logic [CNT_W-1:0]  act_need,
    input  logic              txf_empty,
    input  logic [SLOT_W-1:0] txf_data,
    output logic              txf_pop,
    output logic [SLOT_W-1:0] tx_slot,
    output logic              tx_slot_vld,
    output logic              tx_underrun
);

    logic [RES_W-1:0]  res_bits, merged, nres_bits;
    logic [CNT_W-1:0]  res_cnt, mcnt, nres_cnt;
    logic [SLOT_W-1:0] slot_c;
    logic              pop_c, under_c;
    logic [IDX_W-1:0]  k;

    always_comb begin
        pop_c     = 1'b0;
        under_c   = 1'b0;
        merged    = res_bits;
        mcnt      = res_cnt;
        nres_bits = res_bits;
        nres_cnt  = res_cnt;
        slot_c    = '0;
        k         = '0;
        if (act_mode == MODE_TRANSP) begin
            under_c   = txf_empty;
            pop_c     = !txf_empty;
            slot_c    = ((txf_empty ? {SLOT_W{1'b1}} : txf_data) & act_mask)
                      | (act_fill & ~act_mask);
            nres_bits = '0;
            nres_cnt  = '0;
        end else begin
            if (res_cnt < act_need) begin
                if (txf_empty) begin
                    under_c = 1'b1;
                end else begin
                    pop_c  = 1'b1;
                    merged = res_bits | (RES_W'(txf_data) << res_cnt);
                    mcnt   = res_cnt + CNT_W'(SLOT_W);
                end
            end
            for (int i = 0; i < SLOT_W; i++) begin
                if (act_mask[i]) begin
                    slot_c[i] = under_c ? 1'b1 : merged[k];
                    k = k + 1'b1;
                end else begin
                    slot_c[i] = act_fill[i];
                end
            end
            if (!under_c) begin
                nres_bits = merged >> act_need;
                nres_cnt  = mcnt - act_need;
            end
        end
    end

    always_comb begin
        txf_pop = work && pop_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_bits    <= '0;
            res_cnt     <= '0;
            tx_slot     <= '0;
            tx_slot_vld <= 1'b0;
            tx_underrun <= 1'b0;
        end else begin
            tx_slot_vld <= work;
            tx_underrun <= work && under_c;
            if (work) begin
                tx_slot  <= slot_c;
                res_bits <= nres_bits;
                res_cnt  <= nres_cnt;
            end
        end
    end

    AST_RES_BOUND: assert property (@(posedge clk) disable iff (rst)
        res_cnt < CNT_W'(SLOT_W));                                   // R5
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        txf_pop |-> !txf_empty);                                     // R8
    AST_UNDER_NO_POP: assert property (@(posedge clk) disable iff (rst)
        tx_underrun |-> !$past(txf_pop));                            // R8

endmodule

// File: rtl/sbm_rx_path.sv
module sbm_rx_path
    import sbm_pkg::*;
#(
    parameter int SLOT_W = 8,
    localparam int RES_W = 2 * SLOT_W,
    localparam int CNT_W = $clog2(RES_W + 1),
    localparam int GIX_W = $clog2(SLOT_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              work,
    input  sbm_mode_e         act_mode,
    input  logic [SLOT_W-1:0] act_mask,
    input  logic [CNT_W-1:0]  act_need,
    input  logic [SLOT_W-1:0] rx_lat,
    input  logic              rxf_full,
    output logic              rxf_push,
    output logic [SLOT_W-1:0] rxf_data,
    output logic              rx_overrun
);

    logic [RES_W-1:0]  acc_bits, merged, nacc_bits;
    logic [CNT_W-1:0]  acc_cnt, mcnt, nacc_cnt;
    logic [SLOT_W-1:0] gath, byte_c;
    logic [GIX_W-1:0]  k;
    logic              want;

    always_comb begin
        want      = 1'b0;
        byte_c    = '0;
        gath      = '0;
        k         = '0;
        merged    = acc_bits;
        mcnt      = acc_cnt;
        nacc_bits = acc_bits;
        nacc_cnt  = acc_cnt;
        if (act_mode == MODE_TRANSP) begin
            want      = 1'b1;
            byte_c    = rx_lat & act_mask;
            nacc_bits = '0;
            nacc_cnt  = '0;
        end else begin
            for (int i = 0; i < SLOT_W; i++) begin
                if (act_mask[i]) begin
                    gath[k] = rx_lat[i];
                    k = k + 1'b1;
                end
            end
            merged = acc_bits | (RES_W'(gath) << acc_cnt);
            mcnt   = acc_cnt + act_need;
            if (mcnt >= CNT_W'(SLOT_W)) begin
                want      = 1'b1;
                byte_c    = merged[SLOT_W-1:0];
                nacc_bits = merged >> SLOT_W;
                nacc_cnt  = mcnt - CNT_W'(SLOT_W);
            end else begin
                nacc_bits = merged;
                nacc_cnt  = mcnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_bits   <= '0;
            acc_cnt    <= '0;
            rxf_push   <= 1'b0;
            rxf_data   <= '0;
            rx_overrun <= 1'b0;
        end else begin
            rxf_push   <= work && want && !rxf_full;
            rx_overrun <= work && want && rxf_full;
            if (work) begin
                acc_bits <= nacc_bits;
                acc_cnt  <= nacc_cnt;
                if (want && !rxf_full) rxf_data <= byte_c;
            end
        end
    end

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
        acc_cnt < CNT_W'(SLOT_W));                                   // R6
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
        rxf_push |-> !$past(rxf_full));                              // R9
    AST_PUSH_XOR_OVER: assert property (@(posedge clk) disable iff (rst)
        !(rxf_push && rx_overrun));                                  // R9

endmodule

// File: rtl/slot_bitmask_engine.sv
module slot_bitmask_engine
    import sbm_pkg::*;
#(
    parameter int SLOT_W = 8,
    localparam int CNT_W = $clog2(2 * SLOT_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic              cfg_packed,
    input  logic [SLOT_W-1:0] cfg_mask,
    input  logic [SLOT_W-1:0] cfg_fill,
    input  logic              txf_empty,
    input  logic [SLOT_W-1:0] txf_data,
    output logic              txf_pop,
    output logic [SLOT_W-1:0] tx_slot,
    output logic              tx_slot_vld,
    output logic              tx_underrun,
    input  logic [SLOT_W-1:0] rx_slot,
    input  logic              rxf_full,
    output logic              rxf_push,
    output logic [SLOT_W-1:0] rxf_data,
    output logic              rx_overrun
);

    logic              work;
    sbm_mode_e         act_mode;
    logic [SLOT_W-1:0] act_mask, act_fill, rx_lat;
    logic [CNT_W-1:0]  act_need;
    sbm_mode_e         cfg_mode;

    always_comb begin
        cfg_mode = cfg_packed ? MODE_PACKED : MODE_TRANSP;
    end

    sbm_frame_ctrl #(.SLOT_W(SLOT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .frame_stb(frame_stb),
        .cfg_mode (cfg_mode),
        .cfg_mask (cfg_mask),
        .cfg_fill (cfg_fill),
        .rx_slot  (rx_slot),
        .work     (work),
        .act_mode (act_mode),
        .act_mask (act_mask),
        .act_fill (act_fill),
        .act_need (act_need),
        .rx_lat   (rx_lat)
    );

    sbm_tx_path #(.SLOT_W(SLOT_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .work       (work),
        .act_mode   (act_mode),
        .act_mask   (act_mask),
        .act_fill   (act_fill),
        .act_need   (act_need),
        .txf_empty  (txf_empty),
        .txf_data   (txf_data),
        .txf_pop    (txf_pop),
        .tx_slot    (tx_slot),
        .tx_slot_vld(tx_slot_vld),
        .tx_underrun(tx_underrun)
    );

    sbm_rx_path #(.SLOT_W(SLOT_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .work      (work),
        .act_mode  (act_mode),
        .act_mask  (act_mask),
        .act_need  (act_need),
        .rx_lat    (rx_lat),
        .rxf_full  (rxf_full),
        .rxf_push  (rxf_push),
        .rxf_data  (rxf_data),
        .rx_overrun(rx_overrun)
    );

    AST_VLD_TIMING: assert property (@(posedge clk) disable iff (rst)
        tx_slot_vld |-> $past(frame_stb, 2));                        // R10
    AST_FILL_KEPT: assert property (@(posedge clk) disable iff (rst)
        (tx_slot_vld && !$past(frame_stb)) |->
            ((tx_slot & ~act_mask) == (act_fill & ~act_mask)));      // R3
    AST_PUSH_ONLY_FRAME: assert property (@(posedge clk) disable iff (rst)
        (rxf_push || rx_overrun) |-> tx_slot_vld);                   // R10

endmodule

// File: tb/slot_bitmask_engine_test.sv
`timescale 1ns/1ps
module slot_bitmask_engine_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       frame_stb, cfg_packed, txf_empty, rxf_full;
    logic [7:0] cfg_mask, cfg_fill, txf_data, rx_slot;
    logic       txf_pop, tx_slot_vld, tx_underrun, rxf_push, rx_overrun;
    logic [7:0] tx_slot, rxf_data;

    int errors = 0;
    int checks = 0;

    logic [7:0] fq[$];
    bit         tres[$];
    bit         racc[$];

    always #2.5 clk = ~clk;

    slot_bitmask_engine uut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .cfg_packed(cfg_packed),
        .cfg_mask(cfg_mask), .cfg_fill(cfg_fill), .txf_empty(txf_empty),
        .txf_data(txf_data), .txf_pop(txf_pop), .tx_slot(tx_slot),
        .tx_slot_vld(tx_slot_vld), .tx_underrun(tx_underrun), .rx_slot(rx_slot),
        .rxf_full(rxf_full), .rxf_push(rxf_push), .rxf_data(rxf_data),
        .rx_overrun(rx_overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        frame_stb = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tres.delete();
        racc.delete();
    endtask

    // One frame: model first, then drive, then sample at the due cycles.
    task automatic frame(input logic [7:0] m, input logic [7:0] f, input bit pk,
                         input logic [7:0] rs, input bit full);
        bit         e_pop = 0, e_under = 0, e_push = 0, e_over = 0;
        logic [7:0] e_slot = 8'h00, e_rd = 8'h00;
        int         need = $countones(m);
        logic [7:0] head = (fq.size() != 0) ? fq[0] : 8'($urandom);
        if (!pk) begin
            tres.delete();
            racc.delete();
            if (fq.size() == 0) begin e_under = 1; e_slot = m | (f & ~m); end
            else begin e_pop = 1; e_slot = (head & m) | (f & ~m); end
            e_push = !full; e_over = full; e_rd = rs & m;
        end else begin
            if (tres.size() < need) begin
                if (fq.size() == 0) e_under = 1;
                else begin
                    e_pop = 1;
                    for (int b = 0; b < 8; b++) tres.push_back(head[b]);
                end
            end
            for (int i = 0; i < 8; i++) begin
                if (!m[i]) e_slot[i] = f[i];
                else if (e_under) e_slot[i] = 1'b1;
                else e_slot[i] = tres.pop_front();
            end
            for (int i = 0; i < 8; i++) if (m[i]) racc.push_back(rs[i]);
            if (racc.size() >= 8) begin
                for (int b = 0; b < 8; b++) e_rd[b] = racc.pop_front();
                e_push = !full; e_over = full;
            end
        end
        cfg_mask = m; cfg_fill = f; cfg_packed = pk; rx_slot = rs; rxf_full = full;
        txf_empty = (fq.size() == 0); txf_data = head; frame_stb = 1'b1;
        @(posedge clk); @(negedge clk);
        frame_stb = 1'b0;
        cfg_mask = 8'($urandom); cfg_fill = 8'($urandom);
        cfg_packed = 1'($urandom); rx_slot = 8'($urandom);
        chk("R10 R5 R3 pop", {31'd0, txf_pop}, {31'd0, e_pop});
        @(posedge clk); @(negedge clk);
        if (e_pop) void'(fq.pop_front());
        chk("R10 vld", {31'd0, tx_slot_vld}, 32'd1);
        chk("R2 R3 R5 R7 slot", {24'd0, tx_slot}, {24'd0, e_slot});
        chk("R8 underrun", {31'd0, tx_underrun}, {31'd0, e_under});
        chk("R4 R6 push", {31'd0, rxf_push}, {31'd0, e_push});
        chk("R9 overrun", {31'd0, rx_overrun}, {31'd0, e_over});
        if (e_push) chk("R2 R4 R6 rxdata", {24'd0, rxf_data}, {24'd0, e_rd});
        @(posedge clk); @(negedge clk);
        chk("R10 pulse ends", {30'd0, tx_slot_vld, rxf_push}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog: actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D5E_0042));
        cfg_mask = 0; cfg_fill = 0; cfg_packed = 0; txf_empty = 1; txf_data = 0;
        rx_slot = 0; rxf_full = 0;
        do_reset();
        // R1: reset state
        chk("R1 reset outputs",
            {24'd0, tx_slot_vld, txf_pop, tx_underrun, rxf_push, rx_overrun, 3'd0},
            32'd0);
        chk("R1 reset slot", {16'd0, tx_slot, rxf_data}, 32'd0);
        for (int i = 0; i < 40; i++) fq.push_back(8'($urandom));
        // R3 R4 transparent with several masks including zero
        frame(8'hA5, 8'h3C, 0, 8'hFF, 0);
        frame(8'h00, 8'h81, 0, 8'h5A, 0);
        frame(8'hFF, 8'h00, 0, 8'hC3, 0);
        // R1: reservoir partly filled, then reset must empty it
        frame(8'h0F, 8'h00, 1, 8'h12, 0);
        do_reset();
        frame(8'h0F, 8'h00, 1, 8'h34, 0);
        // R7 all-zero mask packed
        frame(8'h00, 8'h3C, 1, 8'hFF, 0);
        // R11 transparent frame empties reservoir
        frame(8'h01, 8'h00, 1, 8'h01, 0);
        frame(8'h01, 8'h00, 0, 8'h01, 0);
        frame(8'h01, 8'h00, 1, 8'h01, 0);
        // R12 two-bit control channel over eight frames
        for (int i = 0; i < 8; i++) frame(8'h03, 8'hFC, 1, 8'($urandom), 0);
        // R8 underrun transparent and packed (reservoir drains first)
        fq.delete();
        frame(8'h3C, 8'h81, 0, 8'h00, 0);
        fq.push_back(8'h96);
        frame(8'h11, 8'h00, 1, 8'h00, 0);
        for (int i = 0; i < 5; i++) frame(8'h11, 8'hEE, 1, 8'h00, 0);
        // R9 overrun in both modes
        frame(8'hF0, 8'h00, 0, 8'hAB, 1);
        frame(8'hFF, 8'h00, 1, 8'hCD, 1);
        // random mix
        for (int n = 0; n < 300; n++) begin
            if (fq.size() < 4 && ($urandom % 8) != 0)
                for (int j = 0; j < 3; j++) fq.push_back(8'($urandom));
            frame(8'($urandom), 8'($urandom), 1'($urandom % 4 != 0),
                  8'($urandom), 1'($urandom % 6 == 0));
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule